// File: doc/BRIEF.md
# Pipelined Converter Code Correction

This block turns the raw sub-quantizer decisions of a four-stage pipelined analog-to-digital converter into one corrected sample word. Each of the four front stages reports a 3-bit decision with its own valid strobe, and a final backend quantizer reports a 4-bit decision. Because every stage works on a given sample one clock later than the stage before it, the decisions for one sample reach the block spread over five consecutive cycles. The block delays each front-stage code by the right number of cycles so that all five codes of a sample sit side by side in one cycle.

Once the codes are aligned, the block combines them by overlapped addition. Each stage code spans three bits but resolves only two, so successive codes are placed two binary positions apart and their spare bit overlaps the next code. This absorbs decision errors of up to a quarter of a stage's weight in either direction. A fixed bias, two units per front stage code by default, is removed, and the result is saturated to the output range. A new sample can be accepted every cycle, and the output word carries a valid flag.

Top module: `adc_pipe_corrector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `outValid` to 0 and `outData` to 0 and discards every code and valid held for alignment, so a sample that is partly delivered before or during reset never produces an output.
- R2: For one sample, front stage k (k = 1 is `stageCode[0]`) presents its code k-1 cycles after stage 1 does, and the backend presents its code 4 cycles after stage 1. The corrected word appears with `outValid` high one cycle after the backend code, which is 5 cycles after the stage 1 code.
- R3: The raw sum is d1·256 + d2·64 + d3·16 + d4·4 + d5, where d1..d4 are the aligned front-stage codes read as unsigned 3-bit numbers and d5 is the 4-bit backend code read as unsigned. Each stage weight is a quarter of the one before it.
- R4: The corrected value is the raw sum minus BIAS·(256 + 64 + 16 + 4). With the default BIAS of 2, this offset is 680.
- R5: When the corrected value is negative, `outData` is 0.
- R6: When the corrected value exceeds 2^OUT_W − 1, `outData` is 2^OUT_W − 1.
- R7: `outValid` is high only when the stage and backend codes aligned for that sample all had their valid strobes high. Each missing strobe suppresses exactly one output.
- R8: While `outValid` is low, `outData` keeps its previous value.
- R9: Different code sets that have the same weighted sum give the same word. Codes produced by an ideal pipeline whose per-stage decision errors stay within a quarter of that stage's weight reproduce the input value exactly.
- R10: Samples may start on consecutive cycles, giving one corrected word per cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stageCode | input | NUM_STAGES x STAGE_W (4x3) | Front-stage codes; element 0 is the first stage |
| stageValid | input | NUM_STAGES (4) | Per-stage code valid strobes |
| backCode | input | BACK_W (4) | Backend quantizer code |
| backValid | input | 1 | Backend code valid strobe |
| outData | output | OUT_W (12) | Corrected sample word |
| outValid | output | 1 | Corrected word valid |

## Verification
The bench drives two copies of the block from the same inputs. The first uses the default parameters (bias 2, 12-bit output), so its outputs can be compared with the input values of a behavioural pipeline model that injects random decision errors. It also reaches the lower saturation bound with all-zero codes. The second copy uses a bias of 0 and an 11-bit output. The largest code set then exceeds 2047, which brings the upper saturation bound and the exact full-scale value within reach, something the default offset and width could never produce. Missing strobes, a reset during a partly delivered sample, and two redundant code sets with equal sums are placed at known cycles, and the exact output latency is checked for every word.

// File: rtl/pipecorr_pkg.sv
package pipecorr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic flush;    // clear every alignment register
    logic capture;  // aligned set is complete: load the corrected word
  } corrStrobe_t;

  // Binary position of front stage stageIdx (0 = first stage)
  function automatic int weightShift(int stageIdx, int numStages, int shiftPerStage);
    return shiftPerStage * (numStages - stageIdx);
  endfunction

  // Total bias carried by the front-stage codes
  function automatic int biasTotal(int numStages, int shiftPerStage, int bias);
    int acc;
    acc = 0;
    for (int i = 0; i < numStages; i++) begin
      acc = acc + (bias << weightShift(i, numStages, shiftPerStage));
    end
    return acc;
  endfunction

endpackage

// File: rtl/pipecorr_delay.sv
module pipecorr_delay #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [DEPTH];

  always_ff @(posedge clk) begin
    if (clear) begin
      for (int j = 0; j < DEPTH; j++) stageQ[j] <= '0;
    end else begin
      stageQ[0] <= din;
      for (int j = 1; j < DEPTH; j++) stageQ[j] <= stageQ[j-1];
    end
  end

  assign dout = stageQ[DEPTH-1];

endmodule

// File: rtl/pipecorr_ctrl.sv
module pipecorr_ctrl
  import pipecorr_pkg::*;
#(
  parameter int NUM_STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_STAGES-1:0] stageValid,
  input  logic                  backValid,
  output corrStrobe_t           strobe,
  output logic                  outValid
);

  logic [NUM_STAGES-1:0] alignedValid;
  logic                  setComplete;

  // R2: stage i valid waits NUM_STAGES - i cycles, matching its code
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_vdly
    pipecorr_delay #(
      .WIDTH(1),
      .DEPTH(NUM_STAGES - i)
    ) u_vdly (
      .clk  (clk),
      .clear(rst),
      .din  (stageValid[i]),
      .dout (alignedValid[i])
    );
  end

  // R7: output only for a complete aligned set
  assign setComplete = (&alignedValid) & backValid;

  always_comb begin
    strobe.flush   = rst;
    strobe.capture = setComplete;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= setComplete;
  end

endmodule

// File: rtl/pipecorr_datapath.sv
module pipecorr_datapath
  import pipecorr_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_W    = 3,
  parameter int BACK_W     = 4,
  parameter int SHIFT      = 2,
  parameter int BIAS       = 2,
  parameter int OUT_W      = 12
) (
  input  logic                                clk,
  input  corrStrobe_t                         strobe,
  input  logic [NUM_STAGES-1:0][STAGE_W-1:0]  stageCode,
  input  logic [BACK_W-1:0]                   backCode,
  output logic [OUT_W-1:0]                    outData
);

  localparam int RAW_W  = STAGE_W + SHIFT * NUM_STAGES + 1;
  localparam int CALC_W = ((RAW_W > OUT_W) ? RAW_W : OUT_W) + 2;
  localparam int OFFSET = biasTotal(NUM_STAGES, SHIFT, BIAS);
  localparam int MAXV   = (1 << OUT_W) - 1;

  logic [NUM_STAGES-1:0][STAGE_W-1:0] alignedCode;
  logic [CALC_W-1:0]                  rawSum;
  logic [CALC_W-1:0]                  diff;
  logic [OUT_W-1:0]                   corrected;

  // R2: code of stage i held NUM_STAGES - i cycles
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_cdly
    pipecorr_delay #(
      .WIDTH(STAGE_W),
      .DEPTH(NUM_STAGES - i)
    ) u_cdly (
      .clk  (clk),
      .clear(strobe.flush),
      .din  (stageCode[i]),
      .dout (alignedCode[i])
    );
  end

  // R3: overlapped addition, each stage two positions below the previous
  always_comb begin
    rawSum = CALC_W'(backCode);
    for (int i = 0; i < NUM_STAGES; i++) begin
      rawSum = rawSum + (CALC_W'(alignedCode[i]) << weightShift(i, NUM_STAGES, SHIFT));
    end
  end

  // R4 offset removal, R5/R6 saturation
  always_comb begin
    diff = rawSum - CALC_W'(OFFSET);
    if (rawSum < CALC_W'(OFFSET))     corrected = '0;
    else if (diff > CALC_W'(MAXV))    corrected = OUT_W'(MAXV);
    else                              corrected = diff[OUT_W-1:0];
  end

  // R8: word held unless a complete set is captured
  always_ff @(posedge clk) begin
    if (strobe.flush)        outData <= '0;
    else if (strobe.capture) outData <= corrected;
  end

endmodule

// File: rtl/adc_pipe_corrector.sv
module adc_pipe_corrector
  import pipecorr_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_W    = 3,
  parameter int BACK_W     = 4,
  parameter int SHIFT      = 2,
  parameter int BIAS       = 2,
  parameter int OUT_W      = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_STAGES-1:0][STAGE_W-1:0] stageCode,
  input  logic [NUM_STAGES-1:0]              stageValid,
  input  logic [BACK_W-1:0]                  backCode,
  input  logic                               backValid,
  output logic [OUT_W-1:0]                   outData,
  output logic                               outValid
);

  corrStrobe_t strobe;

  pipecorr_ctrl #(
    .NUM_STAGES(NUM_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .stageValid(stageValid),
    .backValid (backValid),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  pipecorr_datapath #(
    .NUM_STAGES(NUM_STAGES),
    .STAGE_W   (STAGE_W),
    .BACK_W    (BACK_W),
    .SHIFT     (SHIFT),
    .BIAS      (BIAS),
    .OUT_W     (OUT_W)
  ) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .stageCode(stageCode),
    .backCode (backCode),
    .outData  (outData)
  );

endmodule

// File: rtl/adc_pipe_corrector_chk.sv
module adc_pipe_corrector_chk #(
  parameter int NUM_STAGES = 4,
  parameter int OUT_W      = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_STAGES-1:0] stageValid,
  input logic                  backValid,
  input logic [OUT_W-1:0]      outData,
  input logic                  outValid
);

  // R1: first cycle after a reset edge shows the cleared outputs
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && (outData == '0)));

  // R7: a word needs the backend strobe one cycle earlier
  a_r7_needs_backend: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(backValid));

  // R7: and the last front-stage strobe two cycles earlier
  a_r7_needs_last_stage: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(stageValid[NUM_STAGES-1], 2));

  // R8: word is held across cycles without a valid output
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!outValid && $past(!rst)) |-> $stable(outData));

endmodule

bind adc_pipe_corrector adc_pipe_corrector_chk #(
  .NUM_STAGES(NUM_STAGES),
  .OUT_W     (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stageValid(stageValid),
  .backValid (backValid),
  .outData   (outData),
  .outValid  (outValid)
);

// File: tb/sim_adc_pipe_corrector.sv
module sim_adc_pipe_corrector;

  localparam int MAXC     = 256;
  localparam int WATCHDOG = 200000;

  logic            clk;
  logic            rst;
  logic [3:0][2:0] stageCode;
  logic [3:0]      stageValid;
  logic [3:0]      backCode;
  logic            backValid;
  logic [11:0]     outData0;
  logic            outValid0;
  logic [10:0]     outData1;
  logic            outValid1;

  int checks = 0;
  int errors = 0;
  int cyc    = -1;
  bit done   = 0;

  bit [2:0] sCode [MAXC][4];
  bit       sVal  [MAXC][4];
  bit [3:0] bCode [MAXC];
  bit       bVal  [MAXC];
  bit       rstAt [MAXC];

  typedef struct {
    int    cyc;
    int    exp0;
    int    exp1;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  adc_pipe_corrector u0 (
    .clk(clk), .rst(rst), .stageCode(stageCode), .stageValid(stageValid),
    .backCode(backCode), .backValid(backValid),
    .outData(outData0), .outValid(outValid0)
  );

  adc_pipe_corrector #(.BIAS(0), .OUT_W(11)) u1 (
    .clk(clk), .rst(rst), .stageCode(stageCode), .stageValid(stageValid),
    .backCode(backCode), .backValid(backValid),
    .outData(outData1), .outValid(outValid1)
  );

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int floorDiv(int a, int b);
    int q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int rawOf(int d[5]);
    return d[0] * 256 + d[1] * 64 + d[2] * 16 + d[3] * 4 + d[4];
  endfunction

  task automatic placeCodes(int s, int d[5], bit [4:0] mask);
    for (int k = 0; k < 4; k++) begin
      sCode[s+k][k] = d[k][2:0];
      sVal[s+k][k]  = mask[k];
    end
    bCode[s+4] = d[4][3:0];
    bVal[s+4]  = mask[4];
  endtask

  task automatic pushExp(int s, int exp0, int d[5], string tag);
    expItem_t it;
    int raw;
    raw     = rawOf(d);
    it.cyc  = s + 4;
    it.exp0 = exp0;
    it.exp1 = (raw > 2047) ? 2047 : raw;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  // Behavioural pipeline: errors within a quarter of the stage weight
  task automatic planModel(int s, string tag);
    int d[5];
    int r, x, w, err, q;
    x = int'($urandom_range(0, 1023));
    r = x;
    for (int k = 0; k < 4; k++) begin
      w    = 1 << (2 * (4 - k));
      err  = int'($urandom_range(0, w / 2 - 1)) - w / 4;
      q    = floorDiv(r + err, w);
      d[k] = q + 2;
      r    = r - q * w;
    end
    d[4] = r;
    placeCodes(s, d, 5'b11111);
    pushExp(s, x, d, tag);
  endtask

  task automatic planDirect(int s, int a, int b, int c, int e, int f, int exp0, string tag);
    int d[5];
    d[0] = a; d[1] = b; d[2] = c; d[3] = e; d[4] = f;
    placeCodes(s, d, 5'b11111);
    pushExp(s, exp0, d, tag);
  endtask

  // Monitor / scoreboard
  int last0 = 0;
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (done) break;
      if (rst) begin
        check(outValid0 == 1'b0 && outValid1 == 1'b0, "R1 valid after reset", int'(outValid0), 0);
        check(outData0 == 12'd0, "R1 data after reset", int'(outData0), 0);
        last0 = 0;
      end else if (outValid0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7/R1 unexpected output", int'(outData0), -1);
        end else begin
          it = expQ.pop_front();
          check(cyc == it.cyc, {"R2 latency ", it.tag}, cyc, it.cyc);
          check(int'(outData0) == it.exp0, {"R3/R4 ", it.tag}, int'(outData0), it.exp0);
          check(outValid1 == 1'b1 && int'(outData1) == it.exp1, {"R6 wide sum ", it.tag},
                int'(outData1), it.exp1);
        end
        last0 = int'(outData0);
      end else begin
        check(int'(outData0) == last0, "R8 hold", int'(outData0), last0);
        check(outValid1 == 1'b0, "R7 second copy valid", int'(outValid1), 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Plan and drive
  initial begin
    rst        = 1'b1;
    stageCode  = '0;
    stageValid = '0;
    backCode   = '0;
    backValid  = 1'b0;
    for (int c = 0; c < 4; c++) rstAt[c] = 1'b1;

    // R9, R10: back-to-back model samples
    for (int s = 6; s < 86; s++) planModel(s, "R10 back-to-back R9 model");
    // R9: gapped model samples
    for (int s = 95; s < 158; s += 3) planModel(s, "R9 gapped model");
    // Directed code sets
    planDirect(170, 0, 0, 0, 0, 0,  0,    "R5 all zero clamps low");
    planDirect(171, 7, 7, 7, 7, 15, 1715, "R6 full codes");
    planDirect(172, 2, 2, 2, 2, 0,  0,    "R4 bias point");
    planDirect(173, 7, 3, 3, 3, 3,  1367, "R6 exact full scale");
    planDirect(174, 3, 2, 2, 2, 0,  256,  "R9 redundancy A");
    planDirect(175, 2, 6, 2, 2, 0,  256,  "R9 redundancy B");
    planDirect(176, 2, 2, 2, 2, 1,  1,    "R4 one above bias");
    // R7: stage 3 strobe missing, then backend strobe missing
    begin
      int d[5];
      d[0] = 5; d[1] = 4; d[2] = 3; d[3] = 2; d[4] = 1;
      placeCodes(185, d, 5'b11011);
      placeCodes(190, d, 5'b01111);
    end
    planModel(196, "R7 after missing strobes");
    // R1: reset during a partly delivered sample
    begin
      int d[5];
      d[0] = 6; d[1] = 1; d[2] = 5; d[3] = 3; d[4] = 2;
      placeCodes(205, d, 5'b11111);
      rstAt[207] = 1'b1;
    end
    planModel(215, "R1 after flush");

    for (int c = 0; c < MAXC; c++) begin
      @(negedge clk);
      cyc       = c;
      rst       = rstAt[c];
      for (int k = 0; k < 4; k++) begin
        stageCode[k]  = sCode[c][k];
        stageValid[k] = sVal[c][k];
      end
      backCode  = bCode[c];
      backValid = bVal[c];
    end
    @(negedge clk);
    done = 1;
    check(expQ.size() == 0, "R7 all expected words delivered", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule